// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and calendar date in packed-BCD registers: seconds, minutes, hours, day of week, day of month, month with a century flag, and a two-digit year. It runs on the system clock and advances only on cycles where a 32.768 kHz qualifier input is high. An internal prescaler divides that qualifier down to a one-second tick. The same prescaler supplies the taps for a selectable square-wave output.

A host writes any register through a single-cycle write port and reads any register through a combinational read port. Writing any time or date register restarts the one-second phase. A one-cycle flag marks each second tick so that downstream alarm comparators can sample the new time. One control register holds the square-wave rate select and a bit that stops all counting.

Register addresses: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read as follows: seconds 00h, minutes 00h, hours 00h (24-hour mode), day of week 01h, date 01h, month 01h, year 00h, and control 03h (rate 32768 Hz, counting enabled).
- R2: One second tick occurs for every 2^PRESC_W qualifier cycles. `sec_tick_o` is high for exactly one clock, in the cycle where the advanced time first reads back.
- R3: Seconds and minutes count in BCD from 00 to 59. Leaving 59 returns the field to 00 and advances the next field. A units digit of 9 carries into the tens digit.
- R4: When hours bit 6 is 0 (24-hour mode), hours count in BCD from 00 to 23. Bits 5:4 are the tens digit. Leaving 23:59:59 gives 00:00:00 and advances the day.
- R5: When hours bit 6 is 1 (12-hour mode), bit 5 is PM (1 = PM) and bits 4:0 hold a BCD value from 01 to 12. The sequence runs 11 AM to 12 PM to 01 PM, and 12 to 01 keeps the PM flag. The step from 11 PM to 12 AM advances the day.
- R6: On each day advance, the day of week (3 bits) counts 1 through 7 and then returns to 1.
- R7: The date wraps to 01 and advances the month after day 30 in months 04, 06, 09 and 11, and after day 31 in all other months except 02. In month 02 it wraps after day 29 when the year value is a multiple of 4, year 00 included, and after day 28 otherwise.
- R8: Month counts 01 to 12 in bits 4:0. Leaving month 12 advances the year. When the year rolls from 99 to 00, month bit 7 (the century flag) toggles.
- R9: Control bits 1:0 select the square-wave output: 11 passes the 32.768 kHz qualifier through, 10 gives 1/4 of its rate, 01 gives 1/8, and 00 gives one period per second (prescaler MSB).
- R10: A host write to any of addresses 0 to 6 clears the prescaler, which restarts the one-second and square-wave phase. If that write falls in the same cycle as a tick, the tick is cancelled: the written value stands and no field advances.
- R11: While control bit 7 is 1, the prescaler holds, no tick occurs, the time does not change, and the 32.768 kHz square-wave selection outputs 0.
- R12: Unimplemented register bits are not stored and read as 0. The stored masks are: seconds, minutes and hours 7Fh; day of week 07h; date 3Fh; month 9Fh; year FFh; control 83h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick32k_i | input | 1 | 32.768 kHz count qualifier, one system clock wide |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Host write register address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 3 | Host read register address |
| rd_data_o | output | 8 | Read data for rd_addr_i (combinational) |
| sec_tick_o | output | 1 | One-cycle flag, time just advanced by a second |
| sqw_o | output | 1 | Selected square-wave output |

## Verification
The bench builds the block with PRESC_W = 4, so a second lasts 16 qualifier cycles and the 1 Hz tap is prescaler bit 3. Holding the qualifier high therefore makes every clock a count step. This brings tick alignment, the cancellation of a tick by a coincident write, and all four square-wave taps within a few dozen cycles. Calendar corners such as month ends, leap Februaries, the 12-hour noon and midnight steps and the century toggle are reached by writing the fields just short of the boundary and running one or two seconds.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEC   = 3'd0,
    REG_MIN   = 3'd1,
    REG_HOUR  = 3'd2,
    REG_DOW   = 3'd3,
    REG_DATE  = 3'd4,
    REG_MONTH = 3'd5,
    REG_YEAR  = 3'd6,
    REG_CTRL  = 3'd7
  } rtc_reg_e;

  typedef logic [7:0] bcd8_t;

  // two-digit BCD increment; caller handles wrap
  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_to_bin(bcd8_t v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       run_i,
  input  logic       clear_i,
  input  logic [1:0] rate_i,
  output logic       tick_o,
  output logic       sqw_o
);
  localparam int TAP_Q4  = 1;
  localparam int TAP_Q8  = 2;
  localparam int TAP_SEC = PRESC_W - 1;

  logic [PRESC_W-1:0] cnt_q;
  logic               adv;

  assign adv    = en_i & run_i;
  assign tick_o = adv & (&cnt_q) & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (adv)     cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (rate_i)
      2'b11:   sqw_o = adv;
      2'b10:   sqw_o = cnt_q[TAP_Q4];
      2'b01:   sqw_o = cnt_q[TAP_Q8];
      default: sqw_o = cnt_q[TAP_SEC];
    endcase
  end

  assert_clear_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> (cnt_q == '0));
  assert_hold_stopped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!run_i) && $past(!clear_i)) |-> $stable(cnt_q));
endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap #(
  parameter int          W  = 7,
  parameter logic [7:0]  LO = 8'h00,
  parameter logic [7:0]  HI = 8'h59
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  import bcd_rtc_pkg::*;

  assign wrap_o = (8'(val_i) >= HI);
  assign nxt_o  = wrap_o ? W'(LO) : W'(bcd_inc(8'(val_i)));
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic [6:0] hour_i,
  output logic [6:0] hour_nxt_o,
  output logic       day_o
);
  import bcd_rtc_pkg::*;

  logic       mode12;
  logic       pm;
  logic [4:0] h12;

  assign mode12 = hour_i[6];
  assign pm     = hour_i[5];
  assign h12    = hour_i[4:0];

  always_comb begin
    hour_nxt_o = '0;
    day_o      = 1'b0;
    if (!mode12) begin
      if (hour_i[5:0] >= 6'h23) begin
        hour_nxt_o = 7'h00;
        day_o      = 1'b1;
      end else begin
        hour_nxt_o = {1'b0, 6'(bcd_inc({2'b00, hour_i[5:0]}))};
      end
    end else begin
      if (h12 == 5'h11) begin
        hour_nxt_o = {1'b1, ~pm, 5'h12};
        day_o      = pm;
      end else if (h12 >= 5'h12) begin
        hour_nxt_o = {1'b1, pm, 5'h01};
      end else begin
        hour_nxt_o = {1'b1, pm, 5'(bcd_inc({3'b000, h12}))};
      end
    end
  end
endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step (
  input  logic [5:0] date_i,
  input  logic [4:0] month_i,
  input  logic [7:0] year_i,
  output logic [5:0] date_nxt_o,
  output logic       month_o
);
  import bcd_rtc_pkg::*;

  logic [7:0] ybin;
  logic       leap;
  logic [7:0] last_day;

  assign ybin = bcd_to_bin(year_i);
  assign leap = ((ybin % 8'd4) == 8'd0);

  always_comb begin
    unique case (month_i)
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign month_o    = ({2'b00, date_i} >= last_day);
  assign date_nxt_o = month_o ? 6'h01 : 6'(bcd_inc({2'b00, date_i}));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int PRESC_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick32k_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       sec_tick_o,
  output logic       sqw_o
);
  import bcd_rtc_pkg::*;

  localparam int NUM_SM = 2;  // seconds, minutes share one structure

  logic [6:0] sm_q [NUM_SM];
  logic [6:0] sm_nxt [NUM_SM];
  logic       sm_wrap [NUM_SM];
  logic       sm_en [NUM_SM];

  logic [6:0] hour_q, hour_nxt;
  logic [2:0] dow_q, dow_nxt;
  logic [5:0] date_q, date_nxt;
  logic [4:0] mon_q, mon_nxt;
  logic       cent_q;
  logic [7:0] year_q, year_nxt;
  logic       osc_off_q;
  logic [1:0] rate_q;

  logic time_wr, ctrl_wr, tick;
  logic hour_en, hour_day, day_en, date_carry;
  logic mon_en, mon_wrap, year_en, year_wrap;
  logic dow_wrap_unused;

  assign time_wr = wr_en_i && (wr_addr_i != REG_CTRL);
  assign ctrl_wr = wr_en_i && (wr_addr_i == REG_CTRL);

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tick32k_i),
    .run_i   (~osc_off_q),
    .clear_i (time_wr),
    .rate_i  (rate_q),
    .tick_o  (tick),
    .sqw_o   (sqw_o)
  );

  // carry chain: everything resolves in one clock
  assign sm_en[0] = tick;
  assign sm_en[1] = tick & sm_wrap[0];
  assign hour_en  = sm_en[1] & sm_wrap[1];
  assign day_en   = hour_en & hour_day;
  assign mon_en   = day_en & date_carry;
  assign year_en  = mon_en & mon_wrap;

  for (genvar i = 0; i < NUM_SM; i++) begin : g_sm
    rtc_bcd_wrap #(.W(7), .LO(8'h00), .HI(8'h59)) u_wrap (
      .val_i  (sm_q[i]),
      .nxt_o  (sm_nxt[i]),
      .wrap_o (sm_wrap[i])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   sm_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == 3'(i))        sm_q[i] <= wr_data_i[6:0];
      else if (sm_en[i])                             sm_q[i] <= sm_nxt[i];
    end
  end

  rtc_hour_step u_hour (
    .hour_i     (hour_q),
    .hour_nxt_o (hour_nxt),
    .day_o      (hour_day)
  );

  rtc_bcd_wrap #(.W(3), .LO(8'h01), .HI(8'h07)) u_dow (
    .val_i  (dow_q),
    .nxt_o  (dow_nxt),
    .wrap_o (dow_wrap_unused)
  );

  rtc_date_step u_date (
    .date_i     (date_q),
    .month_i    (mon_q),
    .year_i     (year_q),
    .date_nxt_o (date_nxt),
    .month_o    (date_carry)
  );

  rtc_bcd_wrap #(.W(5), .LO(8'h01), .HI(8'h12)) u_mon (
    .val_i  (mon_q),
    .nxt_o  (mon_nxt),
    .wrap_o (mon_wrap)
  );

  rtc_bcd_wrap #(.W(8), .LO(8'h00), .HI(8'h99)) u_year (
    .val_i  (year_q),
    .nxt_o  (year_nxt),
    .wrap_o (year_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hour_q    <= 7'h00;
      dow_q     <= 3'h1;
      date_q    <= 6'h01;
      mon_q     <= 5'h01;
      cent_q    <= 1'b0;
      year_q    <= 8'h00;
      osc_off_q <= 1'b0;
      rate_q    <= 2'b11;
      sec_tick_o <= 1'b0;
    end else begin
      sec_tick_o <= tick;

      if (wr_en_i && wr_addr_i == REG_HOUR) hour_q <= wr_data_i[6:0];
      else if (hour_en)                     hour_q <= hour_nxt;

      if (wr_en_i && wr_addr_i == REG_DOW)  dow_q <= wr_data_i[2:0];
      else if (day_en)                      dow_q <= dow_nxt;

      if (wr_en_i && wr_addr_i == REG_DATE) date_q <= wr_data_i[5:0];
      else if (day_en)                      date_q <= date_nxt;

      if (wr_en_i && wr_addr_i == REG_MONTH) begin
        mon_q  <= wr_data_i[4:0];
        cent_q <= wr_data_i[7];
      end else begin
        if (mon_en)                mon_q  <= mon_nxt;
        if (year_en && year_wrap)  cent_q <= ~cent_q;
      end

      if (wr_en_i && wr_addr_i == REG_YEAR) year_q <= wr_data_i;
      else if (year_en)                     year_q <= year_nxt;

      if (ctrl_wr) begin
        osc_off_q <= wr_data_i[7];
        rate_q    <= wr_data_i[1:0];
      end
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      REG_SEC:   rd_data_o = {1'b0, sm_q[0]};
      REG_MIN:   rd_data_o = {1'b0, sm_q[1]};
      REG_HOUR:  rd_data_o = {1'b0, hour_q};
      REG_DOW:   rd_data_o = {5'b0, dow_q};
      REG_DATE:  rd_data_o = {2'b0, date_q};
      REG_MONTH: rd_data_o = {cent_q, 2'b0, mon_q};
      REG_YEAR:  rd_data_o = year_q;
      default:   rd_data_o = {osc_off_q, 5'b0, rate_q};
    endcase
  end

  assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);
  assert_sec_bcd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> (sm_q[0] <= 7'h59 && sm_q[0][3:0] <= 4'd9));
  assert_hour12_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hour_en && hour_q[6]) |=> (hour_q[6] && hour_q[4:0] != 5'h00 && hour_q[4:0] <= 5'h12));
  assert_dow_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_en |=> (dow_q >= 3'd1 && dow_q <= 3'd7));
  assert_century_flip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (year_en && year_wrap) |=> (cent_q != $past(cent_q)));
  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr |=> !sec_tick_o);
  assert_osc_freeze_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_off_q |=> !sec_tick_o);
endmodule

// File: tb/bcd_rtc_core_bench.sv
`timescale 1ns/1ps
module bcd_rtc_core_bench;
  localparam int PW = 4;
  localparam int SEC_CYC = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic sec_tick, sqw;

  int n_chk = 0;
  int n_bad = 0;
  int tick_cnt = 0;

  always #2.5 clk = ~clk;

  bcd_rtc_core #(.PRESC_W(PW)) u_bcd_rtc_core (
    .clk_i(clk), .rst_ni(rst_n), .tick32k_i(en),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sec_tick_o(sec_tick), .sqw_o(sqw)
  );

  always @(negedge clk) if (sec_tick) tick_cnt++;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_en(input int k);
    @(negedge clk);
    en = 1'b1;
    repeat (k) @(negedge clk);
    en = 1'b0;
  endtask

  task automatic run(input int secs);
    pulse_en(secs * SEC_CYC);
  endtask

  task automatic chk_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk_val(rd_data, exp, tag);
  endtask

  task automatic set_clock(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
  endtask

  task automatic set_cal(input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
  endtask

  task automatic t_reset;
    chk(3'd0, 8'h00, "R1 sec");
    chk(3'd1, 8'h00, "R1 min");
    chk(3'd2, 8'h00, "R1 hour");
    chk(3'd3, 8'h01, "R1 dow");
    chk(3'd4, 8'h01, "R1 date");
    chk(3'd5, 8'h01, "R1 month");
    chk(3'd6, 8'h00, "R1 year");
    chk(3'd7, 8'h03, "R1 ctrl");
    chk_val({7'd0, sec_tick}, 8'h00, "R1 tick idle");
  endtask

  task automatic t_tick;
    set_clock(8'h00, 8'h00, 8'h00);
    tick_cnt = 0;
    pulse_en(SEC_CYC - 1);
    chk(3'd0, 8'h00, "R2 no advance before wrap");
    pulse_en(1);
    chk(3'd0, 8'h01, "R2 advance at wrap");
    run(3);
    chk(3'd0, 8'h04, "R2 three seconds");
    chk_val(8'(tick_cnt), 8'd4, "R2 tick pulse count");
  endtask

  task automatic t_sec_min;
    set_clock(8'h00, 8'h09, 8'h58);
    run(1);
    chk(3'd0, 8'h59, "R3 sec 59");
    run(1);
    chk(3'd0, 8'h00, "R3 sec wrap");
    chk(3'd1, 8'h10, "R3 min BCD carry");
    set_clock(8'h05, 8'h59, 8'h59);
    run(1);
    chk(3'd1, 8'h00, "R3 min wrap");
    chk(3'd2, 8'h06, "R3 hour advance");
  endtask

  task automatic t_24h;
    wr(3'd3, 8'h07);
    set_cal(8'h15, 8'h03, 8'h21);
    set_clock(8'h23, 8'h59, 8'h59);
    run(1);
    chk(3'd2, 8'h00, "R4 23 to 00");
    chk(3'd0, 8'h00, "R4 sec");
    chk(3'd3, 8'h01, "R6 dow 7 to 1");
    chk(3'd4, 8'h16, "R4 date advance");
    set_clock(8'h09, 8'h59, 8'h59);
    run(1);
    chk(3'd2, 8'h10, "R4 BCD hour carry");
    chk(3'd3, 8'h01, "R6 dow unchanged mid-day");
  endtask

  task automatic t_12h;
    set_clock(8'h51, 8'h59, 8'h59);
    run(1);
    chk(3'd2, 8'h72, "R5 11AM to 12PM");
    set_clock(8'h72, 8'h59, 8'h59);
    run(1);
    chk(3'd2, 8'h61, "R5 12PM to 1PM");
    wr(3'd3, 8'h03);
    set_cal(8'h16, 8'h03, 8'h21);
    set_clock(8'h71, 8'h59, 8'h59);
    run(1);
    chk(3'd2, 8'h52, "R5 11PM to 12AM");
    chk(3'd3, 8'h04, "R6 dow step");
    chk(3'd4, 8'h17, "R5 date advance at midnight");
  endtask

  task automatic month_end(input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr,
                           input logic [7:0] e_dt, input logic [7:0] e_mo, input string tag);
    set_cal(dt, mo, yr);
    set_clock(8'h23, 8'h59, 8'h59);
    run(1);
    chk(3'd4, e_dt, tag);
    chk(3'd5, e_mo, tag);
  endtask

  task automatic t_months;
    month_end(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R7 Feb non-leap");
    month_end(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R7 Feb leap");
    month_end(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R7 Feb year 00 leap");
    month_end(8'h28, 8'h02, 8'h10, 8'h01, 8'h03, "R7 Feb year 10");
    month_end(8'h29, 8'h02, 8'h96, 8'h01, 8'h03, "R7 Feb 29 end");
    month_end(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, "R7 30-day month");
    month_end(8'h30, 8'h01, 8'h21, 8'h31, 8'h01, "R7 31-day month mid");
    month_end(8'h31, 8'h01, 8'h21, 8'h01, 8'h02, "R7 31-day month end");
  endtask

  task automatic t_century;
    month_end(8'h31, 8'h12, 8'h99, 8'h01, 8'h81, "R8 century set");
    chk(3'd6, 8'h00, "R8 year 99 to 00");
    month_end(8'h31, 8'h92, 8'h99, 8'h01, 8'h01, "R8 century clear");
    month_end(8'h31, 8'h12, 8'h41, 8'h01, 8'h01, "R8 year step");
    chk(3'd6, 8'h42, "R8 year BCD step");
  endtask

  task automatic t_sqw;
    wr(3'd7, 8'h02);
    wr(3'd0, 8'h00);
    chk_val({7'd0, sqw}, 8'h00, "R9 rate10 phase 0");
    pulse_en(2);
    chk_val({7'd0, sqw}, 8'h01, "R9 rate10 high");
    pulse_en(2);
    chk_val({7'd0, sqw}, 8'h00, "R9 rate10 low");
    wr(3'd7, 8'h01);
    wr(3'd0, 8'h00);
    pulse_en(4);
    chk_val({7'd0, sqw}, 8'h01, "R9 rate01 high");
    wr(3'd7, 8'h00);
    wr(3'd0, 8'h00);
    pulse_en(SEC_CYC / 2 - 1);
    chk_val({7'd0, sqw}, 8'h00, "R9 rate00 still low");
    pulse_en(1);
    chk_val({7'd0, sqw}, 8'h01, "R9 rate00 high");
    wr(3'd0, 8'h00);
    chk_val({7'd0, sqw}, 8'h00, "R10 1Hz phase restart");
    wr(3'd7, 8'h03);
    chk_val({7'd0, sqw}, 8'h00, "R9 rate11 en low");
    @(negedge clk); en = 1'b1; #1;
    chk_val({7'd0, sqw}, 8'h01, "R9 rate11 en high");
    @(negedge clk); en = 1'b0;
    wr(3'd0, 8'h00);
  endtask

  task automatic t_resync;
    wr(3'd0, 8'h10);
    en = 1'b1;
    repeat (SEC_CYC - 1) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30;
    @(negedge clk);
    wr_en = 1'b0; en = 1'b0;
    #1;
    chk_val({7'd0, sec_tick}, 8'h00, "R10 tick cancelled");
    chk(3'd0, 8'h30, "R10 write wins over tick");
    pulse_en(SEC_CYC - 1);
    chk(3'd0, 8'h30, "R10 phase restarted");
    pulse_en(1);
    chk(3'd0, 8'h31, "R10 next tick");
  endtask

  task automatic t_osc;
    wr(3'd7, 8'h83);
    set_clock(8'h12, 8'h34, 8'h20);
    tick_cnt = 0;
    run(2);
    chk(3'd0, 8'h20, "R11 sec frozen");
    chk(3'd1, 8'h34, "R11 min frozen");
    chk_val(8'(tick_cnt), 8'd0, "R11 no tick");
    @(negedge clk); en = 1'b1; #1;
    chk_val({7'd0, sqw}, 8'h00, "R11 32k output gated");
    @(negedge clk); en = 1'b0;
    wr(3'd7, 8'h03);
    pulse_en(SEC_CYC);
    chk(3'd0, 8'h21, "R11 resumes");
  endtask

  task automatic t_mask;
    wr(3'd0, 8'hFF); chk(3'd0, 8'h7F, "R12 sec mask");
    wr(3'd3, 8'hFF); chk(3'd3, 8'h07, "R12 dow mask");
    wr(3'd4, 8'hFF); chk(3'd4, 8'h3F, "R12 date mask");
    wr(3'd5, 8'hFF); chk(3'd5, 8'h9F, "R12 month mask");
    wr(3'd7, 8'hFF); chk(3'd7, 8'h83, "R12 ctrl mask");
    wr(3'd7, 8'h03);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_sec_min();
    t_24h();
    t_12h();
    t_months();
    t_century();
    t_sqw();
    t_resync();
    t_osc();
    t_mask();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule